// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Binary Counter

This block is a synchronous binary counter, eight bits wide by default, that can step up or down by one or take a new value from a set of preset inputs. Loading and counting both happen on the rising clock edge. Nothing changes the state between edges. There is no reset pin. A user sets a known state by loading it.

Counting needs two active-low enables, and both must be low. One is a parallel enable, shared by every stage of a chain. The other is a trickle enable, which carries the carry or borrow from one stage to the next. The active-low terminal-count output goes low when the state sits at the end of the current direction: all ones when counting up, all zeros when counting down. It only does so while the trickle enable is low. Wiring each stage's terminal count to the next stage's trickle enable builds a wider counter that still steps on a single edge.

Internally, a small decoder sorts each cycle's controls into one of five named operations: OP_LOAD, OP_HOLD_P, OP_HOLD_T, OP_UP and OP_DOWN. The datapath applies that operation to the state register.

Top module: `casc_updn_counter`

## Requirements
- R1: While `load_n` is low at a rising edge, the state takes `din` on that edge, whatever the values of `cep_n`, `cet_n` and `up_dn` (operation OP_LOAD).
- R2: While `load_n` is high and `cep_n` is high at a rising edge, the state keeps its value (operation OP_HOLD_P).
- R3: While `load_n` is high and `cet_n` is high, the state keeps its value at the edge (operation OP_HOLD_T), and `tc_n` stays high for as long as `cet_n` is high.
- R4: While `load_n` is high, both enables are low and `up_dn` is 1, the state increases by one at the edge (operation OP_UP).
- R5: While `load_n` is high, both enables are low and `up_dn` is 0, the state decreases by one at the edge (operation OP_DOWN).
- R6: Counting wraps modulo 2^WIDTH in both directions: all ones steps up to zero, and zero steps down to all ones.
- R7: `tc_n` is low exactly when `cet_n` is low and either `up_dn` is 1 with the state all ones, or `up_dn` is 0 with the state zero. The output is combinational and does not depend on `cep_n`.
- R8: The state never changes between rising edges, even when any input changes.
- R9: Two instances, with the low stage's `tc_n` driving the high stage's `cet_n` and all other controls shared, behave as one up/down counter of twice the width. The high stage's `tc_n` is the terminal count of the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| load_n | input | 1 | Active-low preset enable |
| din | input | WIDTH | Preset value |
| up_dn | input | 1 | Direction: 1 counts up, 0 counts down |
| cep_n | input | 1 | Active-low parallel count enable |
| cet_n | input | 1 | Active-low trickle count enable, also gates `tc_n` |
| q | output | WIDTH | Counter state |
| tc_n | output | 1 | Active-low terminal count |

## Verification
The state result (`q`) is due one rising edge after the controls are applied. The bench drives inputs on the falling edge and compares `q` with its model 1 ns after the next rising edge. `tc_n` is combinational, so it is checked 1 ns after the inputs change, against the state already held. At that same point the bench confirms that `q` has not moved in response to the new inputs. In the cascaded pair, the low stage's carry reaches the high stage's enable in the same cycle, so the 16-bit value is likewise due on the single next edge.

// File: rtl/casc_updn_pkg.sv
package casc_updn_pkg;

    // Operation chosen for the coming edge, in priority order of decode.
    typedef enum logic [2:0] {
        OP_LOAD   = 3'd0,
        OP_HOLD_P = 3'd1,
        OP_HOLD_T = 3'd2,
        OP_UP     = 3'd3,
        OP_DOWN   = 3'd4
    } op_e;

endpackage

// File: rtl/casc_updn_op_sel.sv
module casc_updn_op_sel
    import casc_updn_pkg::*;
(
    input  logic load_n,
    input  logic cep_n,
    input  logic cet_n,
    input  logic up_dn,
    output op_e  op
);

    // Preset wins over everything; a high parallel enable is tested first so
    // both hold cases are distinguishable for the next-state logic.
    always_comb begin
        if (!load_n) begin
            op = OP_LOAD;
        end else if (cep_n) begin
            op = OP_HOLD_P;
        end else if (cet_n) begin
            op = OP_HOLD_T;
        end else if (up_dn) begin
            op = OP_UP;
        end else begin
            op = OP_DOWN;
        end
    end

endmodule

// File: rtl/casc_updn_next.sv
module casc_updn_next
    import casc_updn_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    always_comb begin
        unique case (op)
            OP_LOAD:   nxt = din;
            OP_HOLD_P: nxt = cur;
            OP_HOLD_T: nxt = cur;
            OP_UP:     nxt = cur + STEP;
            OP_DOWN:   nxt = cur - STEP;
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/casc_updn_tc.sv
module casc_updn_tc #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             up_dn,
    input  logic             cet_n,
    output logic             tc_n
);

    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] BOT = {WIDTH{1'b0}};

    logic at_end;

    always_comb begin
        at_end = up_dn ? (cur == TOP) : (cur == BOT);
        tc_n   = !(at_end && !cet_n);
    end

endmodule

// File: rtl/casc_updn_counter.sv
module casc_updn_counter
    import casc_updn_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             up_dn,
    input  logic             cep_n,
    input  logic             cet_n,
    output logic [WIDTH-1:0] q,
    output logic             tc_n
);

    op_e              op;
    logic [WIDTH-1:0] state_r;
    logic [WIDTH-1:0] state_nxt;
    logic             tc_raw;

    casc_updn_op_sel u_op_sel (
        .load_n (load_n),
        .cep_n  (cep_n),
        .cet_n  (cet_n),
        .up_dn  (up_dn),
        .op     (op)
    );

    casc_updn_next #(.WIDTH(WIDTH)) u_next (
        .op  (op),
        .cur (state_r),
        .din (din),
        .nxt (state_nxt)
    );

    casc_updn_tc #(.WIDTH(WIDTH)) u_tc (
        .cur   (state_r),
        .up_dn (up_dn),
        .cet_n (cet_n),
        .tc_n  (tc_raw)
    );

    // State register: edge-only, no asynchronous path.
    always_ff @(posedge clk) begin
        state_r <= state_nxt;
    end

    // Output process.
    always_comb begin
        q    = state_r;
        tc_n = tc_raw;
    end

endmodule

// File: rtl/casc_updn_counter_chk.sv
module casc_updn_counter_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             load_n,
    input logic [WIDTH-1:0] din,
    input logic             up_dn,
    input logic             cep_n,
    input logic             cet_n,
    input logic [WIDTH-1:0] q,
    input logic             tc_n
);

    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] BOT = {WIDTH{1'b0}};

    // The state is only defined after the first preset edge.
    logic primed = 1'b0;

    always_ff @(posedge clk) begin
        if (!load_n) primed <= 1'b1;
    end

    AST_PRESET_TAKES: assert property (@(posedge clk) disable iff (!primed)
        !load_n |=> (q == $past(din))); // R1
    AST_HOLD_PAR: assert property (@(posedge clk) disable iff (!primed)
        (load_n && cep_n) |=> $stable(q)); // R2
    AST_HOLD_TRK: assert property (@(posedge clk) disable iff (!primed)
        (load_n && cet_n) |=> $stable(q)); // R3
    AST_TC_GATED: assert property (@(posedge clk) disable iff (!primed)
        cet_n |-> tc_n); // R3
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!primed)
        (load_n && !cep_n && !cet_n && up_dn) |=> (q == WIDTH'($past(q) + 1'b1))); // R4
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!primed)
        (load_n && !cep_n && !cet_n && !up_dn) |=> (q == WIDTH'($past(q) - 1'b1))); // R5
    AST_WRAP_UP: assert property (@(posedge clk) disable iff (!primed)
        (load_n && !cep_n && !cet_n && up_dn && q == TOP) |=> (q == BOT)); // R6
    AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!primed)
        (load_n && !cep_n && !cet_n && !up_dn && q == BOT) |=> (q == TOP)); // R6
    AST_TC_ONLY_AT_END: assert property (@(posedge clk) disable iff (!primed)
        !tc_n |-> (!cet_n && (up_dn ? (q == TOP) : (q == BOT)))); // R7
    AST_TC_AT_END: assert property (@(posedge clk) disable iff (!primed)
        (!cet_n && (up_dn ? (q == TOP) : (q == BOT))) |-> !tc_n); // R7

endmodule

bind casc_updn_counter casc_updn_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .load_n (load_n),
    .din    (din),
    .up_dn  (up_dn),
    .cep_n  (cep_n),
    .cet_n  (cet_n),
    .q      (q),
    .tc_n   (tc_n)
);

// File: tb/tb_casc_updn_counter.sv
module tb_casc_updn_counter;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    // single stage
    logic       load_n = 1'b1, up_dn = 1'b1, cep_n = 1'b1, cet_n = 1'b1;
    logic [7:0] din = '0;
    logic [7:0] q;
    logic       tc_n;

    // cascaded pair
    logic        c_load_n = 1'b1, c_up = 1'b1, c_cep_n = 1'b1, c_cet_n = 1'b1;
    logic [15:0] c_din = '0;
    logic [7:0]  c_q_lo, c_q_hi;
    logic        c_tc_lo, c_tc_hi;

    casc_updn_counter #(.WIDTH(8)) dut (
        .clk(clk), .load_n(load_n), .din(din), .up_dn(up_dn),
        .cep_n(cep_n), .cet_n(cet_n), .q(q), .tc_n(tc_n));

    casc_updn_counter #(.WIDTH(8)) c_lo (
        .clk(clk), .load_n(c_load_n), .din(c_din[7:0]), .up_dn(c_up),
        .cep_n(c_cep_n), .cet_n(c_cet_n), .q(c_q_lo), .tc_n(c_tc_lo));

    casc_updn_counter #(.WIDTH(8)) c_hi (
        .clk(clk), .load_n(c_load_n), .din(c_din[15:8]), .up_dn(c_up),
        .cep_n(c_cep_n), .cet_n(c_tc_lo), .q(c_q_hi), .tc_n(c_tc_hi));

    int checks = 0;
    int fails  = 0;
    int unsigned m8  = 0;
    int unsigned m16 = 0;
    int cycles = 0;

    function automatic int unsigned f_next(int unsigned m, int unsigned mask,
            logic ld_n, int unsigned d, logic cp_n, logic ct_n, logic dir);
        if (!ld_n)            return d & mask;
        if (cp_n || ct_n)     return m;
        if (dir)              return (m + 1) & mask;
        return (m + mask) & mask;
    endfunction

    function automatic logic f_tc(int unsigned m, int unsigned mask,
            logic ct_n, logic dir);
        return !(!ct_n && (dir ? (m == mask) : (m == 0)));
    endfunction

    task automatic chk(string req, int unsigned act, int unsigned exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, check combinational/no-change, then the edge result.
    task automatic step(logic ld, logic [7:0] d, logic dir, logic cp, logic ct,
                        logic cld, logic [15:0] cd, logic cdir, logic ccp, logic cct,
                        string req);
        @(negedge clk);
        load_n = ld; din = d; up_dn = dir; cep_n = cp; cet_n = ct;
        c_load_n = cld; c_din = cd; c_up = cdir; c_cep_n = ccp; c_cet_n = cct;
        #1;
        if (cycles > 0) begin
            chk("R8 q steady between edges", q, m8);
            chk("R7 tc_n decode", tc_n, f_tc(m8, 32'hFF, ct, dir));
            chk("R9 pair value steady", {c_q_hi, c_q_lo}, m16);
            chk("R9 pair terminal count", c_tc_hi, f_tc(m16, 32'hFFFF, cct, cdir));
        end
        @(posedge clk);
        #1;
        m8  = f_next(m8, 32'hFF, ld, d, cp, ct, dir);
        m16 = f_next(m16, 32'hFFFF, cld, cd, ccp, cct, cdir);
        chk(req, q, m8);
        chk("R9 pair after edge", {c_q_hi, c_q_lo}, m16);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        // Establish state by preset (R1), enables high and direction odd.
        step(0, 8'h5A, 0, 1, 1, 0, 16'h12FE, 1, 1, 1, "R1 preset ignores enables");
        chk("R3 tc_n high while cet_n high", tc_n, 1);
        // R2 hold by parallel enable
        step(1, 8'h00, 1, 1, 0, 1, 16'h0, 1, 1, 0, "R2 hold parallel");
        // R3 hold by trickle enable
        step(1, 8'h00, 1, 0, 1, 1, 16'h0, 1, 0, 1, "R3 hold trickle");
        // R4 up, pair carries from FE->FF->100
        step(1, 8'h00, 1, 0, 0, 1, 16'h0, 1, 0, 0, "R4 count up");
        step(1, 8'h00, 1, 0, 0, 1, 16'h0, 1, 0, 0, "R4 count up again");
        step(1, 8'h00, 0, 0, 0, 1, 16'h0, 0, 0, 0, "R5 count down");
        // R6 wraps
        step(0, 8'hFF, 1, 0, 0, 0, 16'hFFFF, 1, 0, 0, "R1 preset all ones");
        chk("R7 tc_n low at top going up", tc_n, 0);
        step(1, 8'h00, 1, 1, 0, 1, 16'h0, 1, 1, 0, "R2 hold at top");
        chk("R7 tc_n independent of cep_n", tc_n, 0);
        step(1, 8'h00, 1, 0, 0, 1, 16'h0, 1, 0, 0, "R6 wrap up to zero");
        step(1, 8'h00, 0, 0, 0, 1, 16'h0, 0, 0, 0, "R6 wrap down to all ones");
        step(0, 8'h00, 1, 0, 0, 0, 16'h0100, 0, 0, 0, "R1 preset zero");
        step(1, 8'h00, 0, 0, 1, 1, 16'h0, 0, 0, 0, "R3 hold at zero, pair borrows");
        chk("R3 tc_n held high", tc_n, 1);
        // Constrained random
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] r;
            logic [15:0] cd;
            r = 8'($urandom);
            cd = 16'($urandom);
            case ($urandom % 4)
                0: cd[7:0] = 8'hFF;
                1: cd[7:0] = 8'h00;
                default: ;
            endcase
            step(($urandom % 16) != 0, r, ($urandom % 8) != 0 ? up_dn : !up_dn,
                 ($urandom % 6) == 0, ($urandom % 6) == 0,
                 ($urandom % 24) != 0, cd, ($urandom % 10) != 0 ? c_up : !c_up,
                 ($urandom % 8) == 0, ($urandom % 8) == 0,
                 "R4 R5 random sequence");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule